// File: doc/BRIEF.md
# Transponder Read Stream Sequencer

This block decides which memory bits a contactless tag sends back to the reader, and when it sends them. After power-on it spends a fixed setup window reading the configuration block (block 0) into a mode register. Modulation stays off during that window. It then runs a repeating stream over the user blocks, from block 1 up to a configurable last block. Each block goes out serially from bit 1 to bit 32. Before a new block starts, the mode register is reloaded from block 0, so a corrupted mode value cannot persist.

Framing is optional and set by the mode. A one-bit-period terminator can come before every block, and a double terminator can follow the last block of the cycle. A wake-up hold-off keeps the tag silent until the reader addresses it. A stop command can silence the tag until the next reset. The write path can restart the stream at block 1 or at a given block. A restart keeps the current mode for the block it names, which lets a freshly programmed configuration take effect only from the following block.

The field clock is the block clock. A single-cycle bit strobe marks each bit boundary. Memory is read through a combinational port: an address goes out and 33 bits come back.

Top module: `rdseq_top`

## Requirements
- R1: During reset, `mod_en`, `term_flag` and `tx_bit` are 0 and `mode_word` is 0. After reset the block drives `mem_addr` = 0 and keeps `mod_en` low for SETUP_CYC field clocks. A `field_gap` pulse restarts that count. At the end of the window, `mode_word` holds `mem_rdata[32:1]` of block 0.
- R2: Let M be the maximum-block field, stored in bits [3:1] of block 0 (`mode_word[2:0]`). With M ≥ 1, blocks are sent in the order 1, 2, …, M and then wrap back to block 1.
- R3: With M = 0, block 0 is sent over and over.
- R4: Each block sends its bits 1 to 32 in that order, one per bit period. Bit i is `mem_rdata[i]`. Bit 0 (the lock bit) is never sent. While a data bit is out, `mem_addr` shows the block being sent.
- R5: Block 0 is re-read before every new block. A change to the stored configuration takes effect from the next block boundary.
- R6: When the block-terminator enable (block 0 bit 4, `mode_word[3]`) is 1, one terminator is sent before every block.
- R7: When the sequence-terminator enable (block 0 bit 5, `mode_word[4]`) is 1 and M ≠ 0, two back-to-back terminators follow the last block. With M = 0 none are sent.
- R8: When the wake-up enable (block 0 bit 6, `mode_word[5]`) is 1, `mod_en` stays low after setup until a `wake_evt` pulse. The stream then starts at the next strobe.
- R9: When the stop-obey bit (block 0 bit 7, `mode_word[6]`) is 0, a `stop_evt` pulse forces `mod_en` low until reset. When that bit is 1, `stop_evt` has no effect.
- R10: `restart_evt` with `restart_here` = 1 restarts the stream at block `restart_blk` from the next strobe. That block is sent under the mode held before the restart. The configuration re-read at its end applies from the following block.
- R11: `restart_evt` with `restart_here` = 0 restarts the stream at block 1 (at block 0 when M = 0).
- R12: A terminator lasts exactly one bit period. During it `term_flag` = 1 and `tx_bit` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Field clock |
| rst_n | input | 1 | Active-low power-on reset |
| bit_stb | input | 1 | One-cycle strobe at every bit boundary (at least 3 clocks apart) |
| field_gap | input | 1 | Field interruption seen during setup |
| wake_evt | input | 1 | Valid wake-up command pulse |
| stop_evt | input | 1 | Stop command pulse |
| restart_evt | input | 1 | Restart request pulse from the write path |
| restart_here | input | 1 | 1: restart at `restart_blk`; 0: restart at block 1 |
| restart_blk | input | 3 | Block to restart at |
| mem_rdata | input | 33 | Memory read data for `mem_addr`, bit 0 = lock bit |
| mem_addr | output | 3 | Memory block address |
| tx_bit | output | 1 | Serial bit to the modulator |
| term_flag | output | 1 | High while a terminator is being sent |
| mod_en | output | 1 | Modulation enable |
| mode_word | output | 32 | Active mode register (block 0 bits 32..1) |

## Verification
Every stream output changes on the clock edge that samples `bit_stb`. The bench therefore takes each sample four field clocks after a strobe. By then the one- or two-cycle configuration and data prefetch has finished, so `mem_addr` again shows the block being sent. The setup window is checked at a fixed clock count after a mid-window gap, against the count the gap implies. Wake-up and restart requests are driven between strobes and are expected to take effect in the unit that follows the next strobe. A mode change made in block 0 is expected to appear only in the unit after the block boundary.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;
    localparam int unsigned BLK_W  = 3;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned BIT_W  = $clog2(WORD_W);

    // field positions inside the 32-bit mode word (block 0 bits 32..1)
    localparam int unsigned MB_LO     = 0;
    localparam int unsigned BT_BIT    = 3;
    localparam int unsigned ST_BIT    = 4;
    localparam int unsigned AOR_BIT   = 5;
    localparam int unsigned STOPN_BIT = 6;

    typedef enum logic [1:0] {RS_LOAD, RS_HOLD, RS_RUN, RS_SILENT} run_e;
    typedef enum logic [2:0] {PH_WAIT, PH_BT, PH_SQ1, PH_SQ2, PH_DAT} ph_e;
    typedef enum logic [1:0] {FT_IDLE, FT_MODE, FT_DATA} fet_e;

    function automatic logic [BLK_W-1:0] maxblk_of(input logic [WORD_W-1:0] m);
        return m[MB_LO +: BLK_W];
    endfunction
endpackage

// File: rtl/rdseq_setup_timer.sv
module rdseq_setup_timer #(
    parameter int unsigned SETUP_CYC = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic gap,
    output logic done
);
    localparam int unsigned CW = $clog2(SETUP_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(SETUP_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!active || gap) begin
            cnt_d = '0;
        end else if (cnt_q != LAST) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = active && !gap && (cnt_q == LAST);
endmodule

// File: rtl/rdseq_next_blk.sv
module rdseq_next_blk #(
    parameter int unsigned BW = 3
) (
    input  logic [BW-1:0] cur,
    input  logic [BW-1:0] max,
    output logic [BW-1:0] nxt,
    output logic          last
);
    always_comb begin
        last = (cur >= max);
        if (max == '0)  nxt = '0;
        else if (last)  nxt = BW'(1);
        else            nxt = cur + 1'b1;
    end
endmodule

// File: rtl/rdseq_bit_mux.sv
module rdseq_bit_mux #(
    parameter int unsigned WW         = 32,
    parameter bit          TERM_LEVEL = 1'b1
) (
    input  logic                  on,
    input  logic                  term,
    input  logic [WW-1:0]         word,
    input  logic [$clog2(WW)-1:0] idx,
    output logic                  tx
);
    always_comb begin
        if (!on)       tx = 1'b0;
        else if (term) tx = TERM_LEVEL;
        else           tx = word[idx];
    end
endmodule

// File: rtl/rdseq_top.sv
module rdseq_top
    import rdseq_pkg::*;
#(
    parameter int unsigned SETUP_CYC  = 256,
    parameter bit          TERM_LEVEL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              field_gap,
    input  logic              wake_evt,
    input  logic              stop_evt,
    input  logic              restart_evt,
    input  logic              restart_here,
    input  logic [BLK_W-1:0]  restart_blk,
    input  logic [WORD_W:0]   mem_rdata,
    output logic [BLK_W-1:0]  mem_addr,
    output logic              tx_bit,
    output logic              term_flag,
    output logic              mod_en,
    output logic [WORD_W-1:0] mode_word
);
    typedef struct packed {
        run_e              run;
        ph_e               ph;
        fet_e              fet;
        logic [BIT_W-1:0]  bitn;
        logic [BLK_W-1:0]  blk;
        logic [BLK_W-1:0]  nblk;
        logic [WORD_W-1:0] word;
        logic [WORD_W-1:0] nword;
        logic [WORD_W-1:0] mode;
        logic [WORD_W-1:0] pend;
    } seq_t;

    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);
    localparam logic [BIT_W-1:0] BIT_PRE  = BIT_W'(WORD_W - 2);

    seq_t q, n;
    logic [WORD_W-1:0] rdata_w;
    logic              setup_done;
    logic              stop_ok;
    logic [BLK_W-1:0]  mb_sel, nb_nxt;
    logic              nb_last;
    logic              enter, load;
    logic              in_term;
    run_e              run_w;

    assign rdata_w = mem_rdata[WORD_W:1];
    assign stop_ok = stop_evt && !q.mode[STOPN_BIT];

    rdseq_setup_timer #(.SETUP_CYC(SETUP_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .active(q.run == RS_LOAD),
        .gap(field_gap), .done(setup_done)
    );

    // during a mode fetch the next block follows the freshly read mode
    assign mb_sel = (q.fet == FT_MODE) ? maxblk_of(rdata_w) : maxblk_of(q.pend);

    rdseq_next_blk #(.BW(BLK_W)) u_nblk (
        .cur(q.blk), .max(mb_sel), .nxt(nb_nxt), .last(nb_last)
    );

    always_comb begin
        n     = q;
        enter = 1'b0;
        load  = 1'b0;

        // background prefetch: configuration first, then the next block word
        if (q.run == RS_RUN || q.run == RS_HOLD) begin
            if (q.fet == FT_MODE) begin
                n.pend = rdata_w;
                n.nblk = nb_nxt;
                n.fet  = FT_DATA;
            end else if (q.fet == FT_DATA) begin
                n.nword = rdata_w;
                n.fet   = FT_IDLE;
            end
        end

        unique case (q.run)
            RS_LOAD: begin
                if (setup_done) begin
                    n.mode = rdata_w;
                    n.pend = rdata_w;
                    n.nblk = (maxblk_of(rdata_w) == '0) ? '0 : BLK_W'(1);
                    n.fet  = FT_DATA;
                    n.ph   = PH_WAIT;
                    n.run  = rdata_w[AOR_BIT] ? RS_HOLD : RS_RUN;
                end
            end
            RS_HOLD: begin
                if (stop_ok) begin
                    n.run = RS_SILENT;
                end else if (wake_evt) begin
                    n.run = RS_RUN;
                    n.ph  = PH_WAIT;
                end
            end
            RS_RUN: begin
                if (stop_ok) begin
                    n.run = RS_SILENT;
                end else if (restart_evt) begin
                    n.ph   = PH_WAIT;
                    n.fet  = FT_DATA;
                    n.pend = q.mode;
                    if (restart_here)                  n.nblk = restart_blk;
                    else if (maxblk_of(q.mode) == '0)  n.nblk = '0;
                    else                               n.nblk = BLK_W'(1);
                end else if (bit_stb) begin
                    unique case (q.ph)
                        PH_WAIT: enter = 1'b1;
                        PH_BT:   load  = 1'b1;
                        PH_SQ1:  n.ph  = PH_SQ2;
                        PH_SQ2:  enter = 1'b1;
                        PH_DAT: begin
                            if (q.bitn != BIT_LAST) begin
                                n.bitn = q.bitn + 1'b1;
                                if (q.bitn == BIT_PRE) n.fet = FT_MODE;
                            end else begin
                                n.mode = q.pend;
                                if (nb_last && q.pend[ST_BIT] && maxblk_of(q.pend) != '0)
                                    n.ph = PH_SQ1;
                                else
                                    enter = 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            default: ;
        endcase

        if (enter) begin
            if (q.pend[BT_BIT]) n.ph = PH_BT;
            else                load = 1'b1;
        end
        if (load) begin
            n.ph   = PH_DAT;
            n.bitn = '0;
            n.blk  = q.nblk;
            n.word = q.nword;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{run: RS_LOAD, ph: PH_WAIT, fet: FT_IDLE, default: '0};
        end else begin
            q <= n;
        end
    end

    always_comb begin
        if (q.run == RS_LOAD || q.fet == FT_MODE) mem_addr = '0;
        else if (q.fet == FT_DATA)                mem_addr = q.nblk;
        else                                      mem_addr = q.blk;
    end

    assign mod_en    = (q.run == RS_RUN) && (q.ph != PH_WAIT);
    assign in_term   = (q.ph == PH_BT) || (q.ph == PH_SQ1) || (q.ph == PH_SQ2);
    assign term_flag = mod_en && in_term;
    assign mode_word = q.mode;
    assign run_w     = q.run;

    rdseq_bit_mux #(.WW(WORD_W), .TERM_LEVEL(TERM_LEVEL)) u_mux (
        .on(mod_en), .term(in_term), .word(q.word), .idx(q.bitn), .tx(tx_bit)
    );
endmodule

// File: rtl/rdseq_chk.sv
module rdseq_chk
    import rdseq_pkg::*;
#(
    parameter bit TERM_LEVEL = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_stb,
    input logic              stop_evt,
    input logic              restart_evt,
    input logic              mod_en,
    input logic              term_flag,
    input logic              tx_bit,
    input logic [BLK_W-1:0]  mem_addr,
    input logic [WORD_W-1:0] mode_word,
    input run_e              run_s
);
    AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (run_s == RS_LOAD) |-> (mem_addr == '0 && !mod_en)); // R1

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (run_s == RS_HOLD) |-> !mod_en); // R8

    AST_SILENT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (run_s == RS_SILENT) |=> (run_s == RS_SILENT && !mod_en)); // R9

    AST_STOP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_evt && mode_word[STOPN_BIT] && run_s == RS_RUN) |=> (run_s != RS_SILENT)); // R9

    AST_TERM_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        term_flag |-> (tx_bit == TERM_LEVEL && mod_en)); // R12

    AST_UNIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_en && $past(mod_en) && !$past(bit_stb) && !$past(restart_evt))
            |-> ($stable(term_flag) && $stable(tx_bit))); // R12
endmodule

bind rdseq_top rdseq_chk #(.TERM_LEVEL(TERM_LEVEL)) u_chk (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .stop_evt(stop_evt),
    .restart_evt(restart_evt), .mod_en(mod_en), .term_flag(term_flag),
    .tx_bit(tx_bit), .mem_addr(mem_addr), .mode_word(mode_word), .run_s(run_w)
);

// File: tb/rdseq_top_tb.sv
module rdseq_top_tb;
    localparam int CLK_P = 10;
    localparam int BIT_P = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_stb = 1'b0;
    logic field_gap = 1'b0, wake_evt = 1'b0, stop_evt = 1'b0;
    logic restart_evt = 1'b0, restart_here = 1'b0;
    logic [2:0] restart_blk = 3'd0;
    logic [32:0] mem [8];
    logic [32:0] mem_rdata;
    logic [2:0]  mem_addr;
    logic        tx_bit, term_flag, mod_en;
    logic [31:0] mode_word;

    int total = 0;
    int bad = 0;
    logic s_mod, s_term, s_tx;
    logic [2:0]  s_addr;
    logic [31:0] s_mode;
    bit pending = 0;

    assign mem_rdata = mem[mem_addr];

    rdseq_top u_dut (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .field_gap(field_gap),
        .wake_evt(wake_evt), .stop_evt(stop_evt), .restart_evt(restart_evt),
        .restart_here(restart_here), .restart_blk(restart_blk),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .tx_bit(tx_bit),
        .term_flag(term_flag), .mod_en(mod_en), .mode_word(mode_word)
    );

    always #(CLK_P/2) clk = ~clk;

    initial begin : stb_gen
        int div;
        div = 0;
        forever begin
            @(negedge clk);
            bit_stb = (div == 0);
            div = (div + 1) % BIT_P;
        end
    end

    function automatic logic [32:0] mkmode(input int mb, input bit bt, input bit st,
                                           input bit aor, input bit stopn);
        logic [2:0] m;
        m = mb[2:0];
        return {25'd0, stopn, aor, st, bt, m, 1'b0};
    endfunction

    function automatic logic [32:0] mkdata(input int k);
        logic [31:0] p;
        p = (32'h9E37_79B9 * k[31:0]) ^ 32'hC3A5_0F1E;
        return {p, 1'b1};
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [32:0] m0);
        mem[0] = m0;
        for (int k = 1; k < 8; k++) mem[k] = mkdata(k);
        rst_n = 1'b0;
        pending = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic get_unit();
        do @(posedge clk); while (!bit_stb);
        repeat (4) @(negedge clk);
        s_mod = mod_en; s_term = term_flag; s_tx = tx_bit;
        s_addr = mem_addr; s_mode = mode_word;
    endtask

    task automatic sync();
        int n;
        n = 0;
        get_unit();
        while (!s_mod && n < 400) begin
            get_unit();
            n++;
        end
        pending = 1;
    endtask

    task automatic exp_unit(input bit t, input bit b, input int blk, input string tag);
        logic [5:0] act, exp;
        if (pending) pending = 0;
        else get_unit();
        act = {s_mod, s_term, s_tx, (t ? 3'd0 : s_addr)};
        exp = {1'b1, t, b, (t ? 3'd0 : blk[2:0])};
        check(act == exp, tag, int'(act), int'(exp));
    endtask

    task automatic check_blocks(input int first, input int mb, input bit bt, input bit st,
                                input int nb, input string tag);
        int b;
        b = first;
        for (int k = 0; k < nb; k++) begin
            if (bt) exp_unit(1'b1, 1'b1, b, tag);
            for (int i = 1; i <= 32; i++) exp_unit(1'b0, mem[b][i], b, tag);
            if (b >= mb) begin
                if (st && mb != 0) begin
                    exp_unit(1'b1, 1'b1, b, tag);
                    exp_unit(1'b1, 1'b1, b, tag);
                end
                b = (mb == 0) ? 0 : 1;
            end else begin
                b = b + 1;
            end
        end
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1;
        @(negedge clk);
        sig = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [32:0] m_old, m_new;

        // R1: reset state and setup window restarted by a gap
        mem[0] = mkmode(3, 1, 1, 0, 1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check({mod_en, term_flag, tx_bit} == 3'b000 && mode_word == 32'd0,
              "R1 reset outputs", int'({mod_en, term_flag, tx_bit}), 0);
        do_reset(mkmode(3, 1, 1, 0, 1));
        repeat (100) @(negedge clk);
        pulse(field_gap);
        repeat (250) @(negedge clk);
        check(!mod_en && mem_addr == 3'd0, "R1 setup restarted by gap",
              int'({mod_en, mem_addr}), 0);
        sync();
        check(s_mode == mem[0][32:1], "R1 mode loaded", int'(s_mode), int'(mem[0][32:1]));
        check_blocks(1, 3, 1, 1, 7, "R2 R4 R6 R7 R12 stream");

        // R3: maximum block 0 repeats block 0, no sequence terminator (R7)
        do_reset(mkmode(0, 0, 1, 0, 1));
        sync();
        check_blocks(0, 0, 0, 1, 3, "R3 R7 block0 only");

        // R2: full wrap over seven blocks, no framing
        do_reset(mkmode(7, 0, 0, 0, 1));
        sync();
        check_blocks(1, 7, 0, 0, 9, "R2 R4 wrap");

        // R5: configuration change picked up at the next block boundary
        do_reset(mkmode(2, 0, 0, 0, 1));
        sync();
        m_new = mkmode(3, 1, 0, 0, 1);
        mem[0] = m_new;
        check_blocks(1, 2, 0, 0, 1, "R5 old mode block");
        check_blocks(2, 3, 1, 0, 4, "R5 R6 refreshed mode");
        check(s_mode == m_new[32:1], "R5 mode_word refreshed", int'(s_mode), int'(m_new[32:1]));

        // R8: wake-up hold-off
        do_reset(mkmode(2, 0, 0, 1, 1));
        repeat (500) @(negedge clk);
        check(!mod_en && !tx_bit, "R8 held before wake", int'({mod_en, tx_bit}), 0);
        pulse(wake_evt);
        sync();
        check_blocks(1, 2, 0, 0, 3, "R8 after wake");

        // R9: stop ignored when stop-obey bit is 1
        do_reset(mkmode(2, 0, 0, 0, 1));
        sync();
        pulse(stop_evt);
        check_blocks(1, 2, 0, 0, 2, "R9 stop ignored");

        // R9: stop obeyed when stop-obey bit is 0
        do_reset(mkmode(2, 0, 0, 0, 0));
        sync();
        pulse(stop_evt);
        begin
            int on_cnt;
            on_cnt = 0;
            for (int u = 0; u < 20; u++) begin
                get_unit();
                if (s_mod || s_tx) on_cnt++;
            end
            check(on_cnt == 0, "R9 silenced after stop", on_cnt, 0);
        end

        // R10: restart at programmed block 0 keeps the old mode for that block
        m_old = mkmode(3, 0, 0, 0, 1);
        do_reset(m_old);
        sync();
        check_blocks(1, 3, 0, 0, 1, "R10 before restart");
        m_new = mkmode(2, 1, 0, 0, 1);
        mem[0] = m_new;
        restart_here = 1'b1;
        restart_blk = 3'd0;
        pulse(restart_evt);
        get_unit();
        pending = 1;
        check(s_mode == m_old[32:1], "R10 old mode during block0", int'(s_mode), int'(m_old[32:1]));
        check_blocks(0, 3, 0, 0, 1, "R10 block0 old framing");
        get_unit();
        pending = 1;
        check(s_mode == m_new[32:1], "R10 new mode after block0", int'(s_mode), int'(m_new[32:1]));
        check_blocks(1, 2, 1, 0, 3, "R10 R6 new framing");

        // R11: restart at block 1
        restart_here = 1'b0;
        restart_blk = 3'd5;
        pulse(restart_evt);
        check_blocks(1, 2, 1, 0, 2, "R11 restart block1");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule